// File: doc/BRIEF.md
# Trigger Result Capture Buffer

This block collects the information produced during a second-stage trigger confirmation cycle and holds it in a two-bank readout buffer. Four independent capture strobes each latch one class of information: the per-term answer bits, the per-term completion bits, the paired reject/accept bits of the confirmation-capable triggers, and the control-signal snapshot. A further pair of strobes records the fired-trigger mask before the cycle starts and again after it ends. The post-cycle mask is taken while the reject/accept results are still held.

Bank selection is slaved to the first-stage buffer selects. Writes go to the bank opposite the one the first stage is writing, because this information is produced after the first stage has already committed its own data. Reads use the same bank as the first stage is reading, so that both sets of results belong to the same event. Once a capture shows a confirmed trigger, any further answer and completion strobes are ignored until the next cycle begins. A word-addressed read port with one cycle of latency presents the selected bank.

Top module: `tcap_buffer`

## Requirements
- R1: A synchronous active-high reset clears every stored word in both banks, the term-capture lock, `rd_data` and `rd_valid` to zero.
- R2: Each class is stored only on a cycle in which its own strobe is high. The value stored is the input sampled in that cycle. Other words of the same bank keep their values.
- R3: A strobe writes into bank `~l1_wr_bank`, as sampled in the strobe cycle. The other bank is left unchanged.
- R4: A read returns the word from bank `l1_rd_bank`, as sampled in the `rd_en` cycle. The address map is: 0 answers, 1 completions, 2 accept bits in [31:16] and reject bits in [15:0], 3 control signals, 4 pre-cycle mask, 5 post-cycle mask. Addresses 6 and 7 read zero.
- R5: `rd_data` and `rd_valid` update on the clock edge that samples `rd_en`. `rd_valid` is high exactly in the cycle after an `rd_en` cycle.
- R6: A reject/accept strobe with at least one accept bit set locks the term capture. From the next cycle on, answer and completion strobes store nothing. Strobes in the same cycle as the locking strobe still store.
- R7: `cyc_start` releases the lock. If it coincides with a locking strobe, the lock stays set. Reject/accept, control and mask capture work regardless of the lock.
- R8: The pre-cycle and post-cycle masks occupy separate words. Writing one leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_wr_bank | input | 1 | First-stage write bank select |
| l1_rd_bank | input | 1 | First-stage read bank select |
| cyc_start | input | 1 | Start of a confirmation cycle; releases the term lock |
| term_answer | input | N_TERMS (32) | Per-term answer bits |
| term_done | input | N_TERMS (32) | Per-term completion bits |
| st_veto | input | N_SPEC (16) | Per-trigger reject bits |
| st_confirm | input | N_SPEC (16) | Per-trigger accept bits |
| ctrl_sig | input | N_CTRL (32) | Control-signal snapshot |
| trig_mask | input | MASK_W (32) | Fired-trigger mask |
| cap_answer_stb | input | 1 | Answer capture strobe |
| cap_done_stb | input | 1 | Completion capture strobe |
| cap_vc_stb | input | 1 | Reject/accept capture strobe |
| cap_ctrl_stb | input | 1 | Control capture strobe |
| cap_pre_stb | input | 1 | Pre-cycle mask capture strobe |
| cap_post_stb | input | 1 | Post-cycle mask capture strobe |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Read word address |
| rd_data | output | DW (32) | Read word |
| rd_valid | output | 1 | Read word valid |

## Verification
The bench uses the default parameters: 32 terms, 16 confirmation-capable triggers, 32 control bits, a 32-bit mask and a 32-bit word. With these values the packed accept/reject word fills the read word exactly, so a slip in the packing of either half shows up at the port. Every class can be written into one bank and read from both, which exposes any inverted or duplicated bank select. The same settings also cover the lock cases: capture in the locking cycle itself, strobes refused while the lock holds, and release by a new cycle start.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int ADDR_W   = 3;
  localparam int N_WORDS  = 6;
  localparam logic [ADDR_W-1:0] ADR_ANS  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DONE = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_VC   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_PRE  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_POST = 3'd5;
endpackage

// File: rtl/tcap_word_store.sv
module tcap_word_store #(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              wr_bank,
  input  logic [W-1:0]      din,
  output logic [1:0][W-1:0] bank_q
);
  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        bank_q[b] <= '0;
      else if (stb && (wr_bank == 1'(b)))
        bank_q[b] <= din;
    end
  end
endmodule

// File: rtl/tcap_term_lock.sv
module tcap_term_lock (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic vc_stb,
  input  logic confirm_any,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (rst)
      locked <= 1'b0;
    else if (vc_stb && confirm_any)
      locked <= 1'b1;
    else if (cyc_start)
      locked <= 1'b0;
  end
endmodule

// File: rtl/tcap_readout.sv
module tcap_readout
  import tcap_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic                           rd_bank,
  input  logic [N_WORDS-1:0][1:0][DW-1:0] words,
  output logic [DW-1:0]                  rd_data,
  output logic                           rd_valid
);
  logic [DW-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < N_WORDS; i++)
      if (rd_addr == ADDR_W'(i))
        sel_word = words[i][rd_bank];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rd_data <= sel_word;
    end
  end
endmodule

// File: rtl/tcap_buffer.sv
module tcap_buffer
  import tcap_pkg::*;
#(
  parameter int N_TERMS = 32,
  parameter int N_SPEC  = 16,
  parameter int N_CTRL  = 32,
  parameter int MASK_W  = 32,
  parameter int DW      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l1_wr_bank,
  input  logic              l1_rd_bank,
  input  logic              cyc_start,
  input  logic [N_TERMS-1:0] term_answer,
  input  logic [N_TERMS-1:0] term_done,
  input  logic [N_SPEC-1:0] st_veto,
  input  logic [N_SPEC-1:0] st_confirm,
  input  logic [N_CTRL-1:0] ctrl_sig,
  input  logic [MASK_W-1:0] trig_mask,
  input  logic              cap_answer_stb,
  input  logic              cap_done_stb,
  input  logic              cap_vc_stb,
  input  logic              cap_ctrl_stb,
  input  logic              cap_pre_stb,
  input  logic              cap_post_stb,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid
);
  localparam int VC_W = 2 * N_SPEC;

  logic                         wr_bank;
  logic                         term_lock;
  logic                         ans_we;
  logic                         done_we;
  logic [VC_W-1:0]              vc_din;
  logic [1:0][N_TERMS-1:0]      ans_q;
  logic [1:0][N_TERMS-1:0]      done_q;
  logic [1:0][VC_W-1:0]         vc_q;
  logic [1:0][N_CTRL-1:0]       ctrl_q;
  logic [1:0][MASK_W-1:0]       pre_q;
  logic [1:0][MASK_W-1:0]       post_q;
  logic [N_WORDS-1:0][1:0][DW-1:0] words;

  assign wr_bank = ~l1_wr_bank;
  assign ans_we  = cap_answer_stb & ~term_lock;
  assign done_we = cap_done_stb & ~term_lock;
  assign vc_din  = {st_confirm, st_veto};

  tcap_term_lock u_lock (
    .clk         (clk),
    .rst         (rst),
    .cyc_start   (cyc_start),
    .vc_stb      (cap_vc_stb),
    .confirm_any (|st_confirm),
    .locked      (term_lock)
  );

  tcap_word_store #(.W(N_TERMS)) u_ans (
    .clk(clk), .rst(rst), .stb(ans_we), .wr_bank(wr_bank),
    .din(term_answer), .bank_q(ans_q));

  tcap_word_store #(.W(N_TERMS)) u_done (
    .clk(clk), .rst(rst), .stb(done_we), .wr_bank(wr_bank),
    .din(term_done), .bank_q(done_q));

  tcap_word_store #(.W(VC_W)) u_vc (
    .clk(clk), .rst(rst), .stb(cap_vc_stb), .wr_bank(wr_bank),
    .din(vc_din), .bank_q(vc_q));

  tcap_word_store #(.W(N_CTRL)) u_ctrl (
    .clk(clk), .rst(rst), .stb(cap_ctrl_stb), .wr_bank(wr_bank),
    .din(ctrl_sig), .bank_q(ctrl_q));

  tcap_word_store #(.W(MASK_W)) u_pre (
    .clk(clk), .rst(rst), .stb(cap_pre_stb), .wr_bank(wr_bank),
    .din(trig_mask), .bank_q(pre_q));

  tcap_word_store #(.W(MASK_W)) u_post (
    .clk(clk), .rst(rst), .stb(cap_post_stb), .wr_bank(wr_bank),
    .din(trig_mask), .bank_q(post_q));

  for (genvar b = 0; b < 2; b++) begin : g_pack
    assign words[ADR_ANS][b]  = DW'(ans_q[b]);
    assign words[ADR_DONE][b] = DW'(done_q[b]);
    assign words[ADR_VC][b]   = DW'(vc_q[b]);
    assign words[ADR_CTRL][b] = DW'(ctrl_q[b]);
    assign words[ADR_PRE][b]  = DW'(pre_q[b]);
    assign words[ADR_POST][b] = DW'(post_q[b]);
  end

  tcap_readout #(.DW(DW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_bank  (l1_rd_bank),
    .words    (words),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/tcap_buffer_chk.sv
module tcap_buffer_chk #(
  parameter int N_TERMS = 32,
  parameter int N_SPEC  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rd_en,
  input logic                    rd_valid,
  input logic                    cap_answer_stb,
  input logic                    cap_vc_stb,
  input logic                    cyc_start,
  input logic [N_SPEC-1:0]       st_confirm,
  input logic                    l1_wr_bank,
  input logic [N_TERMS-1:0]      term_answer,
  input logic                    term_lock,
  input logic [1:0][N_TERMS-1:0] ans_q
);
  // R1
  reset_clears_valid_chk: assert property (@(posedge clk) rst |=> !rd_valid && !term_lock);

  // R5
  read_latency_chk: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid);

  // R5
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst) !rd_en |=> !rd_valid);

  // R3
  write_opposite_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_answer_stb && !term_lock) |=> ans_q[$past(~l1_wr_bank)] == $past(term_answer));

  // R3
  other_bank_kept_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ans_q[$past(l1_wr_bank)] == $past(ans_q[l1_wr_bank]));

  // R6
  locked_answer_held_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_answer_stb && term_lock) |=> $stable(ans_q));

  // R6
  lock_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_vc_stb && (|st_confirm)) |=> term_lock);

  // R7
  lock_release_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_start && !(cap_vc_stb && (|st_confirm))) |=> !term_lock);
endmodule

bind tcap_buffer tcap_buffer_chk #(.N_TERMS(N_TERMS), .N_SPEC(N_SPEC)) u_chk (.*);

// File: tb/tcap_buffer_bench.sv
`timescale 1ns/1ps
module tcap_buffer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        l1_wr_bank = 1'b0, l1_rd_bank = 1'b0, cyc_start = 1'b0;
  logic [31:0] term_answer = '0, term_done = '0, ctrl_sig = '0, trig_mask = '0;
  logic [15:0] st_veto = '0, st_confirm = '0;
  logic        cap_answer_stb = 0, cap_done_stb = 0, cap_vc_stb = 0;
  logic        cap_ctrl_stb = 0, cap_pre_stb = 0, cap_post_stb = 0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tcap_buffer u_tcap_buffer (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic bank, input logic [2:0] adr, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = adr; l1_rd_bank = bank;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R5 valid after read", 32'(rd_valid), 32'd1);
    d = rd_data;
  endtask

  task automatic strobe(input logic wbank, input logic a, input logic dn,
                        input logic vc, input logic ct, input logic pr, input logic po);
    @(negedge clk);
    l1_wr_bank = wbank;
    cap_answer_stb = a; cap_done_stb = dn; cap_vc_stb = vc;
    cap_ctrl_stb = ct; cap_pre_stb = pr; cap_post_stb = po;
    @(negedge clk);
    cap_answer_stb = 0; cap_done_stb = 0; cap_vc_stb = 0;
    cap_ctrl_stb = 0; cap_pre_stb = 0; cap_post_stb = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 6; a++) begin
        rd(1'(b), 3'(a), d);
        chk("R1 cleared word", d, 32'd0);
      end
    @(negedge clk);
    chk("R5 valid low when idle", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_bank_select();
    logic [31:0] d;
    term_answer = 32'hA5A5_1234;
    strobe(1'b0, 1, 0, 0, 0, 0, 0);
    rd(1'b1, 3'd0, d); chk("R3 answer into bank 1", d, 32'hA5A5_1234);
    rd(1'b0, 3'd0, d); chk("R3 bank 0 untouched", d, 32'd0);
    term_done = 32'h0F0F_8001;
    strobe(1'b1, 0, 1, 0, 0, 0, 0);
    rd(1'b0, 3'd1, d); chk("R4 done from bank 0", d, 32'h0F0F_8001);
    rd(1'b1, 3'd1, d); chk("R3 done bank 1 empty", d, 32'd0);
    term_answer = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    rd(1'b1, 3'd0, d); chk("R2 no strobe no store", d, 32'hA5A5_1234);
  endtask

  task automatic t_vc_ctrl();
    logic [31:0] d;
    st_veto = 16'h00F0; st_confirm = 16'h0000; ctrl_sig = 32'h1357_9BDF;
    strobe(1'b0, 0, 0, 1, 1, 0, 0);
    rd(1'b1, 3'd2, d); chk("R4 packed veto/confirm", d, 32'h0000_00F0);
    rd(1'b1, 3'd3, d); chk("R2 control word", d, 32'h1357_9BDF);
    rd(1'b1, 3'd0, d); chk("R2 answer unchanged", d, 32'hA5A5_1234);
    rd(1'b1, 3'd6, d); chk("R4 unused address zero", d, 32'd0);
  endtask

  task automatic t_masks();
    logic [31:0] d;
    trig_mask = 32'h0000_FFFF;
    strobe(1'b1, 0, 0, 0, 0, 1, 0);
    trig_mask = 32'h0000_00FF;
    strobe(1'b1, 0, 0, 0, 0, 0, 1);
    rd(1'b0, 3'd4, d); chk("R8 pre mask", d, 32'h0000_FFFF);
    rd(1'b0, 3'd5, d); chk("R8 post mask", d, 32'h0000_00FF);
    rd(1'b0, 3'd7, d); chk("R4 address 7 zero", d, 32'd0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    strobe(1'b0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); cyc_start = 1; @(negedge clk); cyc_start = 0;
    term_answer = 32'h1111_2222; st_confirm = 16'h8001; st_veto = 16'h0002;
    strobe(1'b0, 1, 0, 1, 0, 0, 0);
    rd(1'b1, 3'd0, d); chk("R6 same-cycle answer stored", d, 32'h1111_2222);
    rd(1'b1, 3'd2, d); chk("R7 vc stored", d, 32'h8001_0002);
    term_answer = 32'h3333_4444; term_done = 32'h5555_6666; ctrl_sig = 32'h7777_8888;
    st_confirm = 16'h0; st_veto = 16'h0;
    strobe(1'b0, 1, 1, 0, 1, 0, 0);
    rd(1'b1, 3'd0, d); chk("R6 locked answer ignored", d, 32'h1111_2222);
    rd(1'b1, 3'd1, d); chk("R6 locked done ignored", d, 32'd0);
    rd(1'b1, 3'd3, d); chk("R7 control captured while locked", d, 32'h7777_8888);
    @(negedge clk); cyc_start = 1; @(negedge clk); cyc_start = 0;
    strobe(1'b0, 1, 1, 0, 0, 0, 0);
    rd(1'b1, 3'd0, d); chk("R7 answer after release", d, 32'h3333_4444);
    rd(1'b1, 3'd1, d); chk("R7 done after release", d, 32'h5555_6666);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bank_select();
    t_vc_ctrl();
    t_masks();
    t_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule